// File: doc/BRIEF.md
# Pipelined Triple-DES EDE Encryption Core

This block encrypts 64-bit blocks with triple DES in encrypt-decrypt-encrypt order, fully unrolled into 48 registered Feistel round stages. A new plaintext block can enter on every clock with a valid flag. The ciphertext leaves a fixed number of cycles later, one result per clock, in the order the blocks arrived.

Key expansion is done elsewhere. The 48 round subkeys, each 48 bits wide, arrive on one wide static input and must not change while blocks are in flight. Each of the three DES passes has its own initial permutation, sixteen rounds, half swap and final permutation. The round function itself is built from package functions, so a reference model can restate it independently.

Top module: `tdes_ede_pipe`

## Requirements
- R1: While `rst` is high every stage valid bit is cleared. `out_valid` is low on the cycle after a reset edge, and blocks that were in flight when reset was asserted never appear at the output.
- R2: A block sampled with `in_valid` high on a rising edge appears with `out_valid` high after exactly 47 further rising edges. There are 48 stage registers, and the first is loaded on the sampling edge.
- R3: One block is accepted on every clock, including back-to-back. Results leave in arrival order, none is lost, and an idle input cycle yields an idle output cycle (no spurious `out_valid`).
- R4: `out_block` equals E_K3(D_K2(E_K1(P))). Subkey slice i sits at `subkeys[48*i+47:48*i]`. The first pass uses slices 0..15 in rising order, the second uses slices 16..31, and the third uses slices 32..47 in rising order.
- R5: The middle pass applies its slices in reverse, from slice 31 down to slice 16. So when slices 0..15 equal slices 16..31, the whole transform collapses to a single encryption with the last key group, and the halves are carried unchanged across each pass seam.
- R6: Each DES pass applies the initial permutation, then 16 rounds of (L, R) -> (R, L xor f(R, k)). It then forms {R16, L16} and applies the final permutation. f expands R to 48 bits, XORs the subkey, and feeds eight 6-bit groups to eight S-boxes (outer two bits pick the row, inner four the column) before the 32-bit P permutation. Bit 1 of every standard table is the MSB.
- R7: With all three key groups equal the output is single DES: key 133457799BBCDFF1 maps 0123456789ABCDEF to 85E813540F0AB405, and key 0123456789ABCDEF maps 4E6F772069732074 to 3FA40E8A984D4815.
- R8: With the three keys 0123456789ABCDEF, 23456789ABCDEF01 and 456789ABCDEF0123, the blocks 5468652071756663, 6B2062726F776E20 and 666F78206A756D70 map to A826FD8CE53B855F, CCE21C8112256FE6 and 68D5C05DD9B6B900.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid chain |
| in_valid | input | 1 | Plaintext block present this cycle |
| in_block | input | 64 | Plaintext block, DES bit 1 at bit 63 |
| subkeys | input | 2304 | 48 round subkeys of 48 bits; slice i at [48*i+47:48*i] |
| out_valid | output | 1 | Ciphertext block present this cycle |
| out_block | output | 64 | Ciphertext block |

## Verification
Published single-DES answers with three equal key groups separate a faulty S-box, permutation or round wiring from correct behaviour. The published three-key vector adds key-group routing and direction. Setting the first two key groups equal while the third differs must reduce the output to one encryption with the third key, which only holds when the middle pass runs its subkeys in reverse. A burst of random blocks, compared against an independent bit-numbered model, exposes dropped, reordered or late results. A stream with random gaps does the same for idle slots, all-zero and all-ones blocks probe the extremes of the S-box inputs, and a reset in the middle of a stream must swallow every block in flight.

// File: rtl/tdes_pkg.sv
package tdes_pkg;
  localparam int BLK_W    = 64;
  localparam int HALF_W   = 32;
  localparam int SUBKEY_W = 48;
  localparam int NUM_SBOX = 8;

  // Eight substitution boxes, 64 nibbles each, row-major, first entry in the top nibble
  localparam logic [255:0] SBOX_TBL [NUM_SBOX] = '{
    256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D,
    256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9,
    256'hA09E63F51DC7B428_D709346A285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C,
    256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E,
    256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453,
    256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D,
    256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C,
    256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B
  };

  // P permutation, 1-based source positions, MSB is position 1
  localparam int P_SRC [HALF_W] = '{
    16, 7, 20, 21, 29, 12, 28, 17, 1, 15, 23, 26, 5, 18, 31, 10,
    2, 8, 24, 14, 32, 27, 3, 9, 19, 13, 30, 6, 22, 11, 4, 25
  };

  // Source position (1-based) of initial-permutation output bit o (0-based from MSB)
  function automatic int ip_source(input int o);
    int row, col, base;
    row  = o / 8;
    col  = o % 8;
    base = (row < 4) ? (58 + 2 * row) : (57 + 2 * (row - 4));
    return base - 8 * col;
  endfunction

  function automatic logic [BLK_W-1:0] init_perm(input logic [BLK_W-1:0] x);
    logic [BLK_W-1:0] y;
    for (int o = 0; o < BLK_W; o++) y[BLK_W-1-o] = x[BLK_W - ip_source(o)];
    return y;
  endfunction

  // Inverse of init_perm
  function automatic logic [BLK_W-1:0] final_perm(input logic [BLK_W-1:0] x);
    logic [BLK_W-1:0] y;
    for (int o = 0; o < BLK_W; o++) y[BLK_W - ip_source(o)] = x[BLK_W-1-o];
    return y;
  endfunction

  // 32 -> 48 expansion: group g takes positions 4g .. 4g+5 (1-based, wrapping)
  function automatic logic [SUBKEY_W-1:0] expand_half(input logic [HALF_W-1:0] r);
    logic [SUBKEY_W-1:0] e;
    int src;
    for (int g = 0; g < NUM_SBOX; g++)
      for (int j = 0; j < 6; j++) begin
        src = ((4 * g + j - 1 + HALF_W) % HALF_W) + 1;
        e[SUBKEY_W-1-(6*g+j)] = r[HALF_W - src];
      end
    return e;
  endfunction

  function automatic logic [3:0] sbox_lookup(input int box, input logic [5:0] six);
    int n;
    n = 16 * int'({six[5], six[0]}) + int'(six[4:1]);
    return SBOX_TBL[box][255 - 4*n -: 4];
  endfunction

  function automatic logic [HALF_W-1:0] sbox_layer(input logic [SUBKEY_W-1:0] x);
    logic [HALF_W-1:0] s;
    for (int g = 0; g < NUM_SBOX; g++)
      s[HALF_W-1-4*g -: 4] = sbox_lookup(g, x[SUBKEY_W-1-6*g -: 6]);
    return s;
  endfunction

  function automatic logic [HALF_W-1:0] p_perm(input logic [HALF_W-1:0] x);
    logic [HALF_W-1:0] y;
    for (int i = 0; i < HALF_W; i++) y[HALF_W-1-i] = x[HALF_W - P_SRC[i]];
    return y;
  endfunction

  function automatic logic [BLK_W-1:0] swap_halves(input logic [BLK_W-1:0] x);
    return {x[HALF_W-1:0], x[BLK_W-1:HALF_W]};
  endfunction
endpackage

// File: rtl/tdes_round_fn.sv
module tdes_round_fn
  import tdes_pkg::*;
(
  input  logic [HALF_W-1:0]   r_half,
  input  logic [SUBKEY_W-1:0] subkey,
  output logic [HALF_W-1:0]   f_out
);
  logic [SUBKEY_W-1:0] expanded;
  logic [SUBKEY_W-1:0] keyed;
  logic [HALF_W-1:0]   substituted;

  assign expanded    = expand_half(r_half);
  assign keyed       = expanded ^ subkey;
  assign substituted = sbox_layer(keyed);
  assign f_out       = p_perm(substituted);
endmodule

// File: rtl/tdes_stage.sv
module tdes_stage
  import tdes_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [BLK_W-1:0]    in_halves,
  input  logic [SUBKEY_W-1:0] subkey,
  output logic                out_valid,
  output logic [BLK_W-1:0]    out_halves
);
  logic [HALF_W-1:0] left_in, right_in, f_val;
  logic              vld_q;
  logic [BLK_W-1:0]  data_q;

  assign left_in  = in_halves[BLK_W-1:HALF_W];
  assign right_in = in_halves[HALF_W-1:0];

  tdes_round_fn u_fn (
    .r_half (right_in),
    .subkey (subkey),
    .f_out  (f_val)
  );

  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else     vld_q <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) data_q <= {right_in, left_in ^ f_val};
  end

  assign out_valid  = vld_q;
  assign out_halves = data_q;
endmodule

// File: rtl/tdes_ede_pipe.sv
module tdes_ede_pipe
  import tdes_pkg::*;
#(
  parameter  int PASSES          = 3,
  parameter  int ROUNDS_PER_PASS = 16,
  localparam int STAGES          = PASSES * ROUNDS_PER_PASS,
  localparam int KEYS_W          = STAGES * SUBKEY_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BLK_W-1:0]  in_block,
  input  logic [KEYS_W-1:0] subkeys,
  output logic              out_valid,
  output logic [BLK_W-1:0]  out_block
);
  logic [STAGES-1:0] stage_vld;
  logic [BLK_W-1:0]  stage_q   [STAGES];
  logic [STAGES-1:0] stage_vin;
  logic [BLK_W-1:0]  stage_din [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    localparam int PASS   = s / ROUNDS_PER_PASS;
    localparam int ROUND  = s % ROUNDS_PER_PASS;
    localparam int KEY_IX = (PASS % 2 == 1) ? (PASS * ROUNDS_PER_PASS + ROUNDS_PER_PASS - 1 - ROUND) : s;

    if (s == 0) begin : g_entry
      assign stage_vin[s] = in_valid;
      assign stage_din[s] = init_perm(in_block);
    end else if (ROUND == 0) begin : g_seam
      // close previous pass (swap + final permutation), open the next (initial permutation)
      assign stage_vin[s] = stage_vld[s-1];
      assign stage_din[s] = init_perm(final_perm(swap_halves(stage_q[s-1])));
    end else begin : g_chain
      assign stage_vin[s] = stage_vld[s-1];
      assign stage_din[s] = stage_q[s-1];
    end

    tdes_stage u_stage (
      .clk        (clk),
      .rst        (rst),
      .in_valid   (stage_vin[s]),
      .in_halves  (stage_din[s]),
      .subkey     (subkeys[KEY_IX*SUBKEY_W +: SUBKEY_W]),
      .out_valid  (stage_vld[s]),
      .out_halves (stage_q[s])
    );

    if (s > 0 && ROUND != 0) begin : g_chain_chk
      // R6
      round_chain_chk: assert property (@(posedge clk) disable iff (rst)
        stage_vld[s] |-> stage_q[s][BLK_W-1:HALF_W] == $past(stage_q[s-1][HALF_W-1:0]));
    end else if (s > 0) begin : g_seam_chk
      // R5
      pass_seam_chk: assert property (@(posedge clk) disable iff (rst)
        stage_vld[s] |-> stage_q[s][BLK_W-1:HALF_W] == $past(stage_q[s-1][BLK_W-1:HALF_W]));
    end
  end

  assign out_valid = stage_vld[STAGES-1];
  assign out_block = final_perm(swap_halves(stage_q[STAGES-1]));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (stage_vld == '0));

  // R3
  occupancy_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $countones(stage_vld) ==
      $past($countones(stage_vld)) + int'($past(in_valid)) - int'($past(stage_vld[STAGES-1])));
endmodule

// File: tb/tdes_ede_pipe_test.sv
`timescale 1ns/1ps
module tdes_ede_pipe_test;
  localparam int LAT = 47;
  localparam int KW  = 48 * 48;

  localparam int PC1_T [56] = '{57,49,41,33,25,17,9,1,58,50,42,34,26,18,10,2,59,51,43,35,27,19,11,3,
    60,52,44,36,63,55,47,39,31,23,15,7,62,54,46,38,30,22,14,6,61,53,45,37,29,21,13,5,28,20,12,4};
  localparam int PC2_T [48] = '{14,17,11,24,1,5,3,28,15,6,21,10,23,19,12,4,26,8,16,7,27,20,13,2,
    41,52,31,37,47,55,30,40,51,45,33,48,44,49,39,56,34,53,46,42,50,36,29,32};
  localparam int SHIFT_T [16] = '{1,1,2,2,2,2,2,2,1,2,2,2,2,2,2,1};
  localparam int IP_T [64] = '{58,50,42,34,26,18,10,2,60,52,44,36,28,20,12,4,62,54,46,38,30,22,14,6,
    64,56,48,40,32,24,16,8,57,49,41,33,25,17,9,1,59,51,43,35,27,19,11,3,
    61,53,45,37,29,21,13,5,63,55,47,39,31,23,15,7};
  localparam int E_T [48] = '{32,1,2,3,4,5,4,5,6,7,8,9,8,9,10,11,12,13,12,13,14,15,16,17,
    16,17,18,19,20,21,20,21,22,23,24,25,24,25,26,27,28,29,28,29,30,31,32,1};
  localparam int P_T [32] = '{16,7,20,21,29,12,28,17,1,15,23,26,5,18,31,10,2,8,24,14,32,27,3,9,19,13,30,6,22,11,4,25};
  localparam logic [255:0] SB [8] = '{
    256'hE4D12FB83A6C59070F74E2D1A6CB953841E8D62BFC973A50FC8249175B3EA06D,
    256'hF18E6B34972DC05A3D47F28EC01A69B50E7BA4D158C6932FD8A13F42B67C05E9,
    256'hA09E63F51DC7B428D709346A285ECBF1D6498F30B12C5AE71AD069874FE3B52C,
    256'h7DE3069A1285BC4FD8B56F03472C1AE9A690CB7DF13E52843F06A1D8945BC72E,
    256'h2C417AB6853FD0E9EB2C47D150FA3986421BAD78F9C5630EB8C71E2D6F09A453,
    256'hC1AF92680D34E75BAF427C9561DE0B389EF528C3704A1DB6432C95FABE17608D,
    256'h4B2EF08D3C975A61D0B7491AE35C2F8614BDC37EAF6805926BD814A7950FE23C,
    256'hD2846FB1A93E50C71FD8A374C56B0E927B419CE206ADF35821E74A8DFC90356B};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [63:0] in_block = '0;
  logic [KW-1:0] subkeys = '0;
  logic out_valid;
  logic [63:0] out_block;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [63:0] exp_q [$];
  int stamp_q [$];
  string tag_q [$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tdes_ede_pipe uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_block(in_block),
    .subkeys(subkeys), .out_valid(out_valid), .out_block(out_block)
  );

  // ---------------- independent reference model ----------------
  function automatic logic [15:0][47:0] key_sched(input logic [63:0] k);
    logic [15:0][47:0] ks;
    logic [55:0] cd;
    logic [27:0] c, d;
    for (int i = 0; i < 56; i++) cd[55-i] = k[64-PC1_T[i]];
    c = cd[55:28];
    d = cd[27:0];
    for (int r = 0; r < 16; r++) begin
      for (int n = 0; n < SHIFT_T[r]; n++) begin
        c = {c[26:0], c[27]};
        d = {d[26:0], d[27]};
      end
      cd = {c, d};
      for (int i = 0; i < 48; i++) ks[r][47-i] = cd[56-PC2_T[i]];
    end
    return ks;
  endfunction

  function automatic logic [31:0] ref_f(input logic [31:0] r, input logic [47:0] k);
    logic [47:0] x;
    logic [31:0] s, p;
    logic [5:0] six;
    int idx;
    for (int i = 0; i < 48; i++) x[47-i] = r[32-E_T[i]];
    x = x ^ k;
    for (int g = 0; g < 8; g++) begin
      six = x[47-6*g -: 6];
      idx = 16 * (2 * int'(six[5]) + int'(six[0])) + int'(six[4:1]);
      s[31-4*g -: 4] = 4'((SB[g] >> (4 * (63 - idx))) & 256'hF);
    end
    for (int i = 0; i < 32; i++) p[31-i] = s[32-P_T[i]];
    return p;
  endfunction

  function automatic logic [63:0] ref_des(input logic [63:0] b, input logic [15:0][47:0] ks, input bit dec);
    logic [63:0] t, y;
    logic [31:0] l, r, tmp;
    for (int i = 0; i < 64; i++) t[63-i] = b[64-IP_T[i]];
    l = t[63:32];
    r = t[31:0];
    for (int i = 0; i < 16; i++) begin
      tmp = r;
      r = l ^ ref_f(r, dec ? ks[15-i] : ks[i]);
      l = tmp;
    end
    t = {r, l};
    for (int i = 0; i < 64; i++) y[64-IP_T[i]] = t[63-i];
    return y;
  endfunction

  logic [15:0][47:0] ka, kb, kc;

  function automatic logic [63:0] ref_ede(input logic [63:0] p);
    return ref_des(ref_des(ref_des(p, ka, 1'b0), kb, 1'b1), kc, 1'b0);
  endfunction

  task automatic load_keys(input logic [63:0] k1, input logic [63:0] k2, input logic [63:0] k3);
    ka = key_sched(k1);
    kb = key_sched(k2);
    kc = key_sched(k3);
    for (int i = 0; i < 16; i++) begin
      subkeys[48*i +: 48]      = ka[i];
      subkeys[48*(16+i) +: 48] = kb[i];
      subkeys[48*(32+i) +: 48] = kc[i];
    end
  endtask

  // ---------------- checking ----------------
  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // driver: one block per call, expected value goes to the scoreboard
  task automatic send(input logic [63:0] p, input logic [63:0] e, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_block = p;
    exp_q.push_back(e);
    stamp_q.push_back(cyc + 1);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic drain();
    idle(1);
    while (exp_q.size() != 0) @(negedge clk);
    idle(2);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (stamp_q.size() != 0 && cyc == stamp_q[0] + LAT) begin
        // R2: result due in this cycle
        check(out_valid === 1'b1, "R2", {63'b0, out_valid}, 64'd1);
        if (out_valid === 1'b1) check(out_block === exp_q[0], tag_q[0], out_block, exp_q[0]);
        void'(exp_q.pop_front());
        void'(stamp_q.pop_front());
        void'(tag_q.pop_front());
      end else if (out_valid !== 1'b0) begin
        // R3: no output without a matching input
        check(1'b0, "R3", {63'b0, out_valid}, 64'd0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL R3 watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] p;
    load_keys(64'h133457799BBCDFF1, 64'h133457799BBCDFF1, 64'h133457799BBCDFF1);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: quiet output after reset
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      check(out_valid === 1'b0, "R1", {63'b0, out_valid}, 64'd0);
    end

    // R7: equal key groups give single DES
    send(64'h0123456789ABCDEF, 64'h85E813540F0AB405, "R7");
    drain();
    load_keys(64'h0123456789ABCDEF, 64'h0123456789ABCDEF, 64'h0123456789ABCDEF);
    send(64'h4E6F772069732074, 64'h3FA40E8A984D4815, "R7");
    drain();

    // R8: published three-key vector, back to back
    load_keys(64'h0123456789ABCDEF, 64'h23456789ABCDEF01, 64'h456789ABCDEF0123);
    send(64'h5468652071756663, 64'hA826FD8CE53B855F, "R8");
    send(64'h6B2062726F776E20, 64'hCCE21C8112256FE6, "R8");
    send(64'h666F78206A756D70, 64'h68D5C05DD9B6B900, "R8");
    drain();

    // R5: first two groups equal collapses to one encryption with the third
    load_keys(64'hFEDCBA9876543210, 64'hFEDCBA9876543210, 64'h0F1E2D3C4B5A6978);
    for (int i = 0; i < 6; i++) begin
      p = {$urandom, $urandom};
      send(p, ref_des(p, kc, 1'b0), "R5");
    end
    drain();

    // R6: S-box extremes, R4: random burst back to back with distinct keys
    load_keys(64'h0011223344556677, 64'h8899AABBCCDDEEFF, 64'h1357924680ACE0BD);
    send(64'h0, ref_ede(64'h0), "R6");
    send(64'hFFFFFFFFFFFFFFFF, ref_ede(64'hFFFFFFFFFFFFFFFF), "R6");
    for (int i = 0; i < 64; i++) begin
      p = {$urandom, $urandom};
      send(p, ref_ede(p), "R4");
    end
    drain();

    // R3: stream with random idle gaps, two-key variant
    load_keys(64'h2BD6459F82C5B300, 64'h952C49104881FF48, 64'h2BD6459F82C5B300);
    for (int i = 0; i < 40; i++) begin
      p = {$urandom, $urandom};
      send(p, ref_ede(p), "R3");
      if ($urandom % 3 == 0) idle(1 + $urandom % 4);
    end
    drain();

    // R1: reset in mid-stream discards everything in flight
    for (int i = 0; i < 5; i++) begin
      p = {$urandom, $urandom};
      send(p, ref_ede(p), "R1");
    end
    idle(10);
    rst = 1'b1;
    exp_q.delete();
    stamp_q.delete();
    tag_q.delete();
    idle(2);
    rst = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      check(out_valid === 1'b0, "R1", {63'b0, out_valid}, 64'd0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule